// File: doc/BRIEF.md
# Spare Column Repair Steering

This block sits between a memory array that carries spare bit columns and the logical data port that the rest of the chip sees. After reset it reads a small number of repair records, one per spare, from a non-volatile fuse store through a simple request/acknowledge handshake. It latches each record and then raises a done flag. Until that flag is high, all accesses are held off.

Once repair is active, each valid record names one defective logical column. On a write, the bit meant for that column is also driven onto the spare assigned to the record. On a read, the spare's bit takes the place of the defective column's bit. The logical port therefore always shows the full word width with no hole. Records that are disabled, that point outside the word, or that repeat a column already claimed by an earlier record have no effect.

Top module: `col_repair_mux`

## Requirements
- R1: While reset is held, and right after it is released, `fuseReq` is 1, `fuseAddr` is 0, `repairDone` is 0, and `phyWrEn`, `phyRdEn` and `rdData` are all 0.
- R2: Records are fetched in order, starting at spare 0. A record is captured on each clock edge where `fuseReq` and `fuseAck` are both high, and `fuseAddr` then advances by one. After the edge that captures the last record, `repairDone` is 1 and `fuseReq` is 0, and both stay that way until the next reset.
- R3: While `repairDone` is 0, `phyWrEn` and `phyRdEn` stay 0 and `rdData` reads as 0, whatever `wrEn` and `rdEn` do.
- R4: The main physical columns `phyWrData[DATA_W-1:0]` always carry `wrData` unchanged.
- R5: Spare s is physical bit `DATA_W+s`. When record s is valid, that bit carries `wrData[column of record s]`; otherwise it is driven 0.
- R6: When repair is active, `rdData[c]` is taken from spare s if record s is valid and names column c. Every other bit comes from `phyRdData[c]`.
- R7: A record is 6 bits wide. Bit 5 is the enable and bits 4:0 are the column index. A record whose enable bit is 0 is ignored.
- R8: A record whose index is 16 or greater (DATA_W or above) is ignored.
- R9: If two enabled, in-range records name the same column, only spare 0 is used. Spare 1 is then driven 0, and the read takes its bit from spare 0.
- R10: An acknowledge that arrives after `repairDone` is set does not change the latched repair.
- R11: Once `repairDone` is 1, `phyWrEn` follows `wrEn` and `phyRdEn` follows `rdEn` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fuseReq | output | 1 | Request for a fuse record |
| fuseAddr | output | ADDR_W (1) | Index of the record requested |
| fuseAck | input | 1 | Fuse data valid, captured on this edge |
| fuseData | input | REC_W (6) | Repair record: enable in the MSB, column index below it |
| repairDone | output | 1 | All records latched, accesses allowed |
| wrEn | input | 1 | Logical write request |
| wrData | input | DATA_W (16) | Logical write data |
| rdEn | input | 1 | Logical read request |
| rdData | output | DATA_W (16) | Repaired logical read data |
| phyWrEn | output | 1 | Array write enable |
| phyWrData | output | PHY_W (18) | Array write data, spares in the top bits |
| phyRdEn | output | 1 | Array read enable |
| phyRdData | input | PHY_W (18) | Array read data, spares in the top bits |

## Verification
Only fuse loading involves registers. `fuseAddr` moves, and `repairDone` rises, one clock edge after the acknowledge that completes a record. The bench therefore drives `fuseAck` on a falling edge and checks these outputs on the next falling edge. Write and read steering, and the enable gating, are combinational from the latched records. Those are checked 1 ns after the data inputs change, inside the same cycle. The repair-load cases (disabled, out-of-range, duplicate and edge columns) each start from a fresh reset and a full reload, and the data vectors are applied after that.

// File: rtl/colrep_pkg.sv
package colrep_pkg;

  // Strobes from the load controller to the steering datapath
  typedef struct packed {
    logic       loadEn;   // capture fuseData into record loadIdx
    logic [3:0] loadIdx;  // record slot being loaded
    logic       repairOn; // all records latched, steering live
  } ctrlStrobe_t;

endpackage

// File: rtl/colrep_ctrl.sv
module colrep_ctrl
  import colrep_pkg::*;
#(
  parameter int NUM_SPARES = 2,
  localparam int ADDR_W = (NUM_SPARES > 1) ? $clog2(NUM_SPARES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fuseAck,
  output logic              fuseReq,
  output logic [ADDR_W-1:0] fuseAddr,
  output logic              repairDone,
  output ctrlStrobe_t       strobe
);

  typedef enum logic {ST_LOAD, ST_DONE} loadState_t;

  loadState_t        state;
  logic [ADDR_W-1:0] recCnt;
  logic              lastRec;

  assign lastRec = (recCnt == ADDR_W'(NUM_SPARES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_LOAD;
      recCnt <= '0;
    end else if (state == ST_LOAD && fuseAck) begin
      if (lastRec) state <= ST_DONE;
      else         recCnt <= recCnt + 1'b1;
    end
  end

  always_comb begin
    fuseReq         = (state == ST_LOAD);
    fuseAddr        = recCnt;
    repairDone      = (state == ST_DONE);
    strobe.loadEn   = (state == ST_LOAD) && fuseAck;
    strobe.loadIdx  = 4'(recCnt);
    strobe.repairOn = (state == ST_DONE);
  end

  // R2: done is sticky until reset
  assert_done_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    repairDone |=> repairDone);

  // R2: no fuse request once repair is active
  assert_no_req_after_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    repairDone |-> !fuseReq);

  // R2: the record address advances after each accepted record except the last
  assert_addr_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fuseReq && fuseAck && !lastRec) |=> (fuseAddr == ADDR_W'($past(fuseAddr) + 1'b1)));

endmodule

// File: rtl/colrep_decode.sv
module colrep_decode #(
  parameter int DATA_W     = 16,
  parameter int NUM_SPARES = 2,
  parameter int IDX_W      = 5
) (
  input  logic [NUM_SPARES-1:0]            recEn,
  input  logic [NUM_SPARES-1:0][IDX_W-1:0] recIdx,
  output logic [NUM_SPARES-1:0]            useSpare
);

  logic [NUM_SPARES-1:0] inRange;

  for (genvar s = 0; s < NUM_SPARES; s++) begin : g_range
    assign inRange[s] = recEn[s] && (recIdx[s] < IDX_W'(DATA_W));
  end

  // A later record loses to any earlier live record naming the same column
  always_comb begin
    for (int s = 0; s < NUM_SPARES; s++) begin
      useSpare[s] = inRange[s];
      for (int j = 0; j < s; j++) begin
        if (useSpare[j] && recIdx[j] == recIdx[s]) useSpare[s] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/colrep_datapath.sv
module colrep_datapath
  import colrep_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NUM_SPARES = 2,
  parameter int IDX_W      = 5,
  localparam int REC_W = IDX_W + 1,
  localparam int PHY_W = DATA_W + NUM_SPARES
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [REC_W-1:0]  fuseData,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [PHY_W-1:0]  phyRdData,
  output logic              phyWrEn,
  output logic [PHY_W-1:0]  phyWrData,
  output logic              phyRdEn,
  output logic [DATA_W-1:0] rdData
);

  logic [NUM_SPARES-1:0]            recEnQ;
  logic [NUM_SPARES-1:0][IDX_W-1:0] recIdxQ;
  logic [NUM_SPARES-1:0]            useSpare;
  logic [NUM_SPARES-1:0]            spareWr;
  logic [DATA_W-1:0]                rdSteer;

  for (genvar s = 0; s < NUM_SPARES; s++) begin : g_rec
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        recEnQ[s]  <= 1'b0;
        recIdxQ[s] <= '0;
      end else if (strobe.loadEn && strobe.loadIdx == 4'(s)) begin
        recEnQ[s]  <= fuseData[IDX_W];
        recIdxQ[s] <= fuseData[IDX_W-1:0];
      end
    end
  end

  colrep_decode #(
    .DATA_W(DATA_W), .NUM_SPARES(NUM_SPARES), .IDX_W(IDX_W)
  ) u_decode (
    .recEn(recEnQ), .recIdx(recIdxQ), .useSpare(useSpare)
  );

  // Write steering: copy the defective column's bit onto its spare
  always_comb begin
    for (int s = 0; s < NUM_SPARES; s++) begin
      spareWr[s] = 1'b0;
      for (int c = 0; c < DATA_W; c++) begin
        if (useSpare[s] && recIdxQ[s] == IDX_W'(c)) spareWr[s] = wrData[c];
      end
    end
    phyWrData = {spareWr, wrData};
  end

  // Read steering: spare bit replaces the defective column, spare 0 wins
  always_comb begin
    rdSteer = phyRdData[DATA_W-1:0];
    for (int s = NUM_SPARES - 1; s >= 0; s--) begin
      for (int c = 0; c < DATA_W; c++) begin
        if (useSpare[s] && recIdxQ[s] == IDX_W'(c)) rdSteer[c] = phyRdData[DATA_W + s];
      end
    end
    rdData  = strobe.repairOn ? rdSteer : '0;
    phyWrEn = wrEn && strobe.repairOn;
    phyRdEn = rdEn && strobe.repairOn;
  end

  // R10: the latched repair never moves once steering is live
  assert_rec_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.repairOn |=> ($stable(recEnQ) && $stable(recIdxQ)));

  // R3: no array write before repair is active
  assert_stall_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    phyWrEn |-> strobe.repairOn);

  // R9: at most one spare claims any column
  assert_single_claim_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(useSpare[0] && useSpare[NUM_SPARES-1] && (NUM_SPARES > 1) &&
      recIdxQ[0] == recIdxQ[NUM_SPARES-1]));

endmodule

// File: rtl/col_repair_mux.sv
module col_repair_mux
  import colrep_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NUM_SPARES = 2,
  localparam int IDX_W  = $clog2(DATA_W) + 1,
  localparam int REC_W  = IDX_W + 1,
  localparam int PHY_W  = DATA_W + NUM_SPARES,
  localparam int ADDR_W = (NUM_SPARES > 1) ? $clog2(NUM_SPARES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              fuseReq,
  output logic [ADDR_W-1:0] fuseAddr,
  input  logic              fuseAck,
  input  logic [REC_W-1:0]  fuseData,
  output logic              repairDone,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              phyWrEn,
  output logic [PHY_W-1:0]  phyWrData,
  output logic              phyRdEn,
  input  logic [PHY_W-1:0]  phyRdData
);

  ctrlStrobe_t strobe;

  colrep_ctrl #(.NUM_SPARES(NUM_SPARES)) u_ctrl (
    .clk(clk), .rstN(rstN), .fuseAck(fuseAck), .fuseReq(fuseReq),
    .fuseAddr(fuseAddr), .repairDone(repairDone), .strobe(strobe)
  );

  colrep_datapath #(
    .DATA_W(DATA_W), .NUM_SPARES(NUM_SPARES), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fuseData(fuseData),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .phyRdData(phyRdData),
    .phyWrEn(phyWrEn), .phyWrData(phyWrData), .phyRdEn(phyRdEn), .rdData(rdData)
  );

endmodule

// File: tb/col_repair_mux_tb.sv
module col_repair_mux_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fuseReq;
  logic [0:0]  fuseAddr;
  logic        fuseAck = 1'b0;
  logic [5:0]  fuseData = '0;
  logic        repairDone;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [15:0] rdData;
  logic        phyWrEn;
  logic [17:0] phyWrData;
  logic        phyRdEn;
  logic [17:0] phyRdData = '0;

  int nChecks = 0;
  int nFails  = 0;
  logic [5:0] curR0, curR1;

  always #2 clk = ~clk;

  col_repair_mux u_dut (
    .clk(clk), .rstN(rstN), .fuseReq(fuseReq), .fuseAddr(fuseAddr),
    .fuseAck(fuseAck), .fuseData(fuseData), .repairDone(repairDone),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .phyWrEn(phyWrEn), .phyWrData(phyWrData), .phyRdEn(phyRdEn),
    .phyRdData(phyRdData)
  );

  localparam logic [15:0] VEC_WR [0:7] = '{
    16'h0000, 16'hFFFF, 16'h0020, 16'h1000,
    16'hA5A5, 16'h5A5A, 16'hEFDF, 16'h8001};
  localparam logic [17:0] VEC_RD [0:7] = '{
    18'h00000, 18'h3FFFF, 18'h10000, 18'h20000,
    18'h0FFFF, 18'h2F0F0, 18'h1C3A5, 18'h3EFDF};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected behaviour from R5..R9 (bit 5 enable, bits 4:0 column)
  task automatic model(input logic [15:0] wr, input logic [17:0] prd,
                       output logic [1:0] expSp, output logic [15:0] expRd);
    logic use0, use1;
    use0 = curR0[5] && (curR0[4:0] < 5'd16);
    use1 = curR1[5] && (curR1[4:0] < 5'd16) && !(use0 && curR0[4:0] == curR1[4:0]);
    expSp[0] = use0 ? wr[curR0[3:0]] : 1'b0;
    expSp[1] = use1 ? wr[curR1[3:0]] : 1'b0;
    expRd = prd[15:0];
    if (use1) expRd[curR1[3:0]] = prd[17];
    if (use0) expRd[curR0[3:0]] = prd[16];
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; fuseAck = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic loadFuses(input logic [5:0] a, input logic [5:0] b);
    curR0 = a; curR1 = b;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk("R2 fuseReq during load", 32'(fuseReq), 32'd1);
      chk("R2 fuseAddr order", 32'(fuseAddr), 32'(k));
      fuseData = (k == 0) ? a : b;
      fuseAck = 1'b1;
      @(negedge clk);
      fuseAck = 1'b0;
      if (k == 0) begin
        chk("R2 not done after first record", 32'(repairDone), 32'd0);
        chk("R2 fuseAddr advanced", 32'(fuseAddr), 32'd1);
      end
    end
    chk("R2 done after last record", 32'(repairDone), 32'd1);
    chk("R2 request dropped", 32'(fuseReq), 32'd0);
  endtask

  task automatic applyVec(input string req, input logic [15:0] wr, input logic [17:0] prd);
    logic [1:0]  expSp;
    logic [15:0] expRd;
    @(negedge clk);
    wrData = wr; phyRdData = prd; wrEn = 1'b1; rdEn = 1'b1;
    #1;
    model(wr, prd, expSp, expRd);
    chk({req, " R4 main columns"}, 32'(phyWrData[15:0]), 32'(wr));
    chk({req, " R5 spare write"}, 32'(phyWrData[17:16]), 32'(expSp));
    chk({req, " R6 read steer"}, 32'(rdData), 32'(expRd));
    chk({req, " R11 enables"}, {30'd0, phyWrEn, phyRdEn}, 32'd3);
  endtask

  initial begin
    #(4 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 fuseReq", 32'(fuseReq), 32'd1);
    chk("R1 fuseAddr", 32'(fuseAddr), 32'd0);
    chk("R1 repairDone", 32'(repairDone), 32'd0);
    wrEn = 1'b1; rdEn = 1'b1; phyRdData = 18'h3FFFF; #1;
    chk("R1 outputs quiet", {29'd0, phyWrEn, phyRdEn, |rdData}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {29'd0, fuseReq, repairDone, fuseAddr}, 32'd4);

    // R3: stall while loading
    curR0 = 6'h25; curR1 = 6'h2C;
    fuseData = curR0; fuseAck = 1'b1;
    @(negedge clk);
    fuseAck = 1'b0;
    wrEn = 1'b1; rdEn = 1'b1; phyRdData = 18'h3FFFF; #1;
    chk("R3 phyWrEn stalled", 32'(phyWrEn), 32'd0);
    chk("R3 phyRdEn stalled", 32'(phyRdEn), 32'd0);
    chk("R3 rdData zero", 32'(rdData), 32'd0);
    @(negedge clk);
    fuseData = curR1; fuseAck = 1'b1;
    @(negedge clk);
    fuseAck = 1'b0;
    chk("R2 done", 32'(repairDone), 32'd1);

    // Vector table: column 5 on spare 0, column 12 on spare 1
    for (int i = 0; i < 8; i++) applyVec("R5/R6 table", VEC_WR[i], VEC_RD[i]);

    // R11: enables follow inputs
    @(negedge clk); wrEn = 1'b0; rdEn = 1'b1; #1;
    chk("R11 phyWrEn low", 32'(phyWrEn), 32'd0);
    chk("R11 phyRdEn high", 32'(phyRdEn), 32'd1);

    // R10: late acknowledge ignored
    @(negedge clk); fuseData = 6'h23; fuseAck = 1'b1;
    @(negedge clk); fuseAck = 1'b0;
    applyVec("R10 late ack", 16'h1020, 18'h30000);

    // R7 and R8: disabled record, out-of-range record
    doReset();
    loadFuses(6'h03, 6'h34);
    applyVec("R7/R8 ignored", 16'hFFFF, 18'h30000);
    chk("R7 spare0 zero", 32'(phyWrData[16]), 32'd0);
    chk("R8 spare1 zero", 32'(phyWrData[17]), 32'd0);

    // R9: duplicate column
    doReset();
    loadFuses(6'h27, 6'h27);
    applyVec("R9 duplicate", 16'h0080, 18'h1FFFF & 18'h17F7F);
    chk("R9 spare1 unused", 32'(phyWrData[17]), 32'd0);
    chk("R9 read from spare0", 32'(rdData[7]), 32'd1);

    // Edge columns 15 and 0
    doReset();
    loadFuses(6'h2F, 6'h20);
    applyVec("R6 edge cols", 16'h8001, 18'h20000);
    chk("R6 col0 from spare1", 32'(rdData[0]), 32'd1);
    chk("R6 col15 from spare0", 32'(rdData[15]), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule